// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns a single pulse-width-modulated command into two gate enables for the two switches of a synchronous buck stage. The upper-switch enable follows the command, and the lower-switch enable is its complement. The two enables are never active in the same cycle. The dead time between them adapts to what the power stage reports, and it is not the same in both directions.

When the command falls, the upper switch is released at once. The lower switch is enabled by one of three paths:
- once the switch node has been seen high and has then dropped below its low threshold;
- after a fixed fallback delay, if the node was never seen high;
- after a timeout, whichever of the above applies.

When the command rises, the lower switch is released at once. The upper switch is enabled only after the lower gate has been reported discharged and a further fixed guard delay has passed.

All delays are whole clock cycles. Each one is the nanosecond figure divided by the clock period and rounded up, so a dead time is never shorter than its nanosecond figure. An active-low permission input forces both enables off. A registered flag shows whether the most recent lower-switch turn-on came from the timeout.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: The inputs `pwm_i`, `drv_allow_i`, `sw_hi_i`, `sw_lo_i` and `lsg_lo_i` each pass through a two-stage synchronizer. A change driven between clock edges therefore acts on the outputs after the third following rising edge. With `pwm_i` steady high, `hs_en_o`=1 and `ls_en_o`=0. With `pwm_i` steady low, `hs_en_o`=0 and `ls_en_o`=1.
- R2: While `drv_allow_i` is 0, both `hs_en_o` and `ls_en_o` are 0, whatever `pwm_i` and the comparator inputs do. A drop of `drv_allow_i` clears both outputs within three edges.
- R3: After a falling command, if `sw_hi_i`=1 has been seen since `hs_en_o` fell, `ls_en_o` rises on the first cycle in which `sw_lo_i`=1 is seen. The fixed fallback delay does not apply in this case.
- R4: If `sw_hi_i` has not been seen since `hs_en_o` fell, `ls_en_o` rises exactly D_FIX = ceil(FIX_NS/CLK_PERIOD_NS) cycles after `hs_en_o` fell (24 at the defaults). This holds whatever `sw_lo_i` does.
- R5: `ls_en_o` rises no later than D_TMO = ceil(TMO_NS/CLK_PERIOD_NS) cycles after `hs_en_o` fell (48 at the defaults), even if `sw_lo_i` never asserts.
- R6: After a rising command, `ls_en_o` falls first. `hs_en_o` rises D_HS = ceil(HS_NS/CLK_PERIOD_NS) cycles (8 at the defaults) after the cycle in which `lsg_lo_i`=1 is seen. The minimum gap between `ls_en_o` falling and `hs_en_o` rising is D_HS+1 cycles.
- R7: If the command reverses while a turn-on is pending, that turn-on is abandoned. The sequence for the new level starts at once.
- R8: `hs_en_o` and `ls_en_o` are never 1 in the same cycle. `ls_en_o` never rises in the cycle right after `hs_en_o` was 1.
- R9: During reset, both outputs and `tmo_rel_o` are 0. On leaving reset or on regaining permission, the block starts the sequence for the present command level. For a low command, `ls_en_o` rises 27 cycles after permission is driven high; for a high command with `lsg_lo_i`=1, `hs_en_o` rises 12 cycles after.
- R10: `tmo_rel_o` is updated each time `ls_en_o` turns on: 1 if the timeout path released it, 0 for the comparator or fixed path. If the comparator release and the timeout expiry fall in the same cycle, the comparator wins and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Switching command |
| drv_allow_i | input | 1 | Drive permission; 0 forces both enables off |
| sw_hi_i | input | 1 | Switch node seen high |
| sw_lo_i | input | 1 | Switch node below its low threshold |
| lsg_lo_i | input | 1 | Lower gate below its discharge threshold |
| hs_en_o | output | 1 | Upper-switch gate enable |
| ls_en_o | output | 1 | Lower-switch gate enable |
| tmo_rel_o | output | 1 | Last lower turn-on came from the timeout |

## Verification
The switch-node comparator release and the timeout expiry can land on the same edge. The bench provokes this by raising `sw_lo_i` so that its synchronized value first appears in the last counted cycle of the timeout window. In that case it expects `ls_en_o` after 48 cycles with `tmo_rel_o`=0. With `sw_lo_i` one cycle later, it expects the same delay with the flag set. A reversal of the command in the middle of a wait is also checked: the pending turn-on must never appear, and the opposite enable must come up.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_LS_PREP = 3'd1,
      ST_LS_ON   = 3'd2,
      ST_HS_GATE = 3'd3,
      ST_HS_DLY  = 3'd4,
      ST_HS_ON   = 3'd5
   } gate_state_e;

   // Whole cycles covering a time, rounded up so dead time never shrinks.
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("dtg_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[s] <= '0;
            else         stg[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[s] <= '0;
            else         stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/dtg_timer.sv
module dtg_timer #(
   parameter int unsigned LIMIT = 48,
   parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          run_i,
   output logic [CW-1:0] cnt_o
);

   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_o <= '0;
      else if (clr_i)                cnt_o <= '0;
      else if (run_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
   end

endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl
   import dtg_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 5,
   parameter int unsigned FIX_NS        = 120,
   parameter int unsigned TMO_NS        = 240,
   parameter int unsigned HS_NS         = 40,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwm_i,
   input  logic drv_allow_i,
   input  logic sw_hi_i,
   input  logic sw_lo_i,
   input  logic lsg_lo_i,
   output logic hs_en_o,
   output logic ls_en_o,
   output logic tmo_rel_o
);

   localparam int unsigned D_FIX = ns_to_cycles(FIX_NS, CLK_PERIOD_NS);
   localparam int unsigned D_TMO = ns_to_cycles(TMO_NS, CLK_PERIOD_NS);
   localparam int unsigned D_HS  = ns_to_cycles(HS_NS, CLK_PERIOD_NS);
   localparam int unsigned T_MAX = (D_TMO > D_HS) ? D_TMO : D_HS;
   localparam int unsigned CW    = $clog2(T_MAX + 1);
   localparam logic [CW-1:0] FIX_LAST = CW'(D_FIX - 1);
   localparam logic [CW-1:0] TMO_LAST = CW'(D_TMO - 1);
   localparam logic [CW-1:0] HS_LAST  = CW'(D_HS - 1);

   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be nonzero");
   end
   if (D_FIX == 0 || D_HS == 0) begin : g_bad_delay
      $error("fallback and guard delays must be at least one cycle");
   end
   if (D_TMO <= D_FIX) begin : g_bad_order
      $error("timeout must exceed the fixed fallback delay");
   end

   // ---------------- input synchronization
   logic [4:0] raw_in, syn_in;
   logic       pwm_s, allow_s, sw_hi_s, sw_lo_s, lsg_lo_s;

   assign raw_in = {pwm_i, drv_allow_i, sw_hi_i, sw_lo_i, lsg_lo_i};

   dtg_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   assign {pwm_s, allow_s, sw_hi_s, sw_lo_s, lsg_lo_s} = syn_in;

   // ---------------- sequencer
   gate_state_e st_q, st_d;
   logic        seen_q, seen;
   logic        flag_q, flag_d;
   logic [CW-1:0] cnt;
   logic        moving, timing;

   assign seen   = seen_q | sw_hi_s;
   assign moving = (st_d != st_q);
   assign timing = (st_q == ST_LS_PREP) || (st_q == ST_HS_DLY);

   dtg_timer #(.LIMIT(T_MAX), .CW(CW)) u_timer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (moving),
      .run_i (timing),
      .cnt_o (cnt)
   );

   always_comb begin
      st_d   = st_q;
      flag_d = flag_q;
      if (!allow_s) begin
         st_d = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF:     st_d = pwm_s ? ST_HS_GATE : ST_LS_PREP;
            ST_LS_PREP: begin
               if (pwm_s) begin
                  st_d = ST_HS_GATE;
               end else if (seen && sw_lo_s) begin
                  st_d   = ST_LS_ON;
                  flag_d = 1'b0;
               end else if (cnt >= TMO_LAST) begin
                  st_d   = ST_LS_ON;
                  flag_d = 1'b1;
               end else if (!seen && cnt >= FIX_LAST) begin
                  st_d   = ST_LS_ON;
                  flag_d = 1'b0;
               end
            end
            ST_LS_ON:   if (pwm_s) st_d = ST_HS_GATE;
            ST_HS_GATE: begin
               if (!pwm_s)        st_d = ST_LS_PREP;
               else if (lsg_lo_s) st_d = ST_HS_DLY;
            end
            ST_HS_DLY: begin
               if (!pwm_s)              st_d = ST_LS_PREP;
               else if (cnt >= HS_LAST) st_d = ST_HS_ON;
            end
            ST_HS_ON:   if (!pwm_s) st_d = ST_LS_PREP;
            default:    st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_OFF;
         seen_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         seen_q <= moving ? 1'b0 : ((st_q == ST_LS_PREP) && seen);
         flag_q <= flag_d;
      end
   end

   assign hs_en_o   = (st_q == ST_HS_ON);
   assign ls_en_o   = (st_q == ST_LS_ON);
   assign tmo_rel_o = flag_q;

   // ---------------- checking: off-time runs of each enable
   logic [CW-1:0] hs_off_run, ls_off_run;
   localparam logic [CW-1:0] RUN_TOP = CW'(T_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hs_off_run <= '0;
         ls_off_run <= '0;
      end else begin
         hs_off_run <= hs_en_o ? '0 : ((hs_off_run == RUN_TOP) ? hs_off_run : hs_off_run + 1'b1);
         ls_off_run <= ls_en_o ? '0 : ((ls_off_run == RUN_TOP) ? ls_off_run : ls_off_run + 1'b1);
      end
   end

   p_off_when_blocked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !allow_s |=> (!hs_en_o && !ls_en_o));

   p_timeout_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ls_en_o) && tmo_rel_o) |-> (hs_off_run >= CW'(D_TMO)));

   p_high_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_en_o) |-> (ls_off_run >= CW'(D_HS)));

   p_hs_drops_on_reverse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_en_o && !pwm_s) |=> !hs_en_o);

   p_ls_drops_on_reverse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ls_en_o && pwm_s) |=> !ls_en_o);

   p_gap_before_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ls_en_o) |-> !$past(hs_en_o));

endmodule

// File: tb/deadtime_gate_ctrl_tb_top.sv
module deadtime_gate_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n, pwm, allow, sw_hi, sw_lo, lsg_lo;
   logic hs_en, ls_en, tmo_rel;
   int   n_chk = 0, n_fail = 0, n_overlap = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   deadtime_gate_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .drv_allow_i(allow),
      .sw_hi_i(sw_hi), .sw_lo_i(sw_lo), .lsg_lo_i(lsg_lo),
      .hs_en_o(hs_en), .ls_en_o(ls_en), .tmo_rel_o(tmo_rel)
   );

   // Columns: sw_hi start, sw_lo start (-1 = never), expected delay, expected flag, req code
   localparam int FV [7][5] = '{
      '{-1, -1, 24, 0, 4},
      '{-1,  0, 24, 0, 4},
      '{ 2, 10, 13, 0, 3},
      '{ 2, 30, 33, 0, 3},
      '{ 2, -1, 48, 1, 5},
      '{ 2, 45, 48, 0, 10},
      '{ 2, 46, 48, 1, 10}
   };

   always @(negedge clk) if (hs_en && ls_en) n_overlap++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string req_name(input int code);
      case (code)
         3:       return "R3 comparator release";
         4:       return "R4 fixed fallback";
         5:       return "R5 timeout release";
         default: return "R10 coincidence priority";
      endcase
   endfunction

   task automatic wait_low(input bit which_hs);
      int g = 0;
      while ((which_hs ? hs_en : ls_en) && g < 20) begin
         @(negedge clk); g++;
      end
   endtask

   task automatic fall_case(input int a, input int b, input int exp_d, input int exp_f, input string tag);
      int dly = -1;
      @(negedge clk);
      sw_hi = 0; sw_lo = 0; pwm = 0;
      wait_low(1'b1);
      for (int idx = 0; idx < 80; idx++) begin
         if (ls_en) begin dly = idx; break; end
         sw_hi = (a >= 0) && (idx >= a) && ((b < 0) || (idx < b));
         sw_lo = (b >= 0) && (idx >= b);
         @(negedge clk);
      end
      chk(dly == exp_d, {tag, " delay"}, dly, exp_d);
      chk(tmo_rel == 1'(exp_f), {tag, " flag"}, int'(tmo_rel), exp_f);
      sw_hi = 0; sw_lo = 0; pwm = 1; lsg_lo = 1;
      repeat (30) @(negedge clk);
   endtask

   task automatic rise_case(input int c, input int exp_d);
      int dly = -1;
      @(negedge clk);
      pwm = 1; lsg_lo = (c < 0);
      wait_low(1'b0);
      for (int idx = 0; idx < 60; idx++) begin
         if (hs_en) begin dly = idx; break; end
         lsg_lo = (c < 0) || (idx >= c);
         @(negedge clk);
      end
      chk(dly == exp_d, "R6 high-side guard delay", dly, exp_d);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seen_bad;
      rst_n = 0; pwm = 0; allow = 1; sw_hi = 0; sw_lo = 0; lsg_lo = 0;
      repeat (4) @(negedge clk);
      chk(!hs_en && !ls_en && !tmo_rel, "R9 reset state", int'({hs_en, ls_en, tmo_rel}), 0);
      rst_n = 1;
      repeat (40) @(negedge clk);
      chk(ls_en && !hs_en, "R9 start low command", int'({hs_en, ls_en}), 1);
      chk(ls_en, "R1 low command drives low side", int'(ls_en), 1);
      pwm = 1; lsg_lo = 1;
      repeat (30) @(negedge clk);
      chk(hs_en && !ls_en, "R1 high command drives high side", int'({hs_en, ls_en}), 2);

      // falling-edge vector walk (R3, R4, R5, R10)
      for (int v = 0; v < 7; v++)
         fall_case(FV[v][0], FV[v][1], FV[v][2], FV[v][3], req_name(FV[v][4]));

      // rising-edge guard (R6); fall back to low side between cases
      pwm = 0; lsg_lo = 0;
      repeat (40) @(negedge clk);
      rise_case(-1, 9);
      @(negedge clk); pwm = 0; lsg_lo = 0;
      repeat (40) @(negedge clk);
      rise_case(5, 16);

      // R7 reversal while waiting for low side
      @(negedge clk); pwm = 0; sw_hi = 0; sw_lo = 0;
      wait_low(1'b1);
      seen_bad = 0;
      for (int idx = 0; idx < 40; idx++) begin
         if (ls_en) seen_bad++;
         if (idx == 5) begin pwm = 1; lsg_lo = 1; end
         @(negedge clk);
      end
      chk(seen_bad == 0, "R7 abandoned low-side turn-on", seen_bad, 0);
      chk(hs_en, "R7 high side after reversal", int'(hs_en), 1);

      // R7 reversal while in high-side guard delay
      @(negedge clk); pwm = 0;
      repeat (40) @(negedge clk);
      @(negedge clk); pwm = 1; lsg_lo = 0;
      wait_low(1'b0);
      seen_bad = 0;
      for (int idx = 0; idx < 40; idx++) begin
         if (hs_en) seen_bad++;
         if (idx == 0) lsg_lo = 1;
         if (idx == 4) pwm = 0;
         @(negedge clk);
      end
      chk(seen_bad == 0, "R7 abandoned high-side turn-on", seen_bad, 0);
      chk(ls_en, "R7 low side after reversal", int'(ls_en), 1);

      // R2 disable from high side on
      @(negedge clk); pwm = 1; lsg_lo = 1;
      repeat (30) @(negedge clk);
      allow = 0;
      repeat (3) @(negedge clk);
      chk(!hs_en && !ls_en, "R2 disable clears outputs", int'({hs_en, ls_en}), 0);
      seen_bad = 0;
      for (int idx = 0; idx < 30; idx++) begin
         pwm = idx[2]; sw_hi = idx[1]; sw_lo = idx[0];
         if (hs_en || ls_en) seen_bad++;
         @(negedge clk);
      end
      chk(seen_bad == 0, "R2 outputs held off while blocked", seen_bad, 0);

      // R9 re-enable with low command
      pwm = 0; sw_hi = 0; sw_lo = 0;
      repeat (5) @(negedge clk);
      allow = 1;
      repeat (26) @(negedge clk);
      chk(!ls_en, "R9 low side not before fallback", int'(ls_en), 0);
      @(negedge clk);
      chk(ls_en && !tmo_rel, "R9 low side after fallback", int'({ls_en, tmo_rel}), 2);

      // R9 re-enable with high command
      allow = 0;
      repeat (5) @(negedge clk);
      pwm = 1; lsg_lo = 1;
      repeat (5) @(negedge clk);
      allow = 1;
      repeat (11) @(negedge clk);
      chk(!hs_en, "R9 high side not before guard", int'(hs_en), 0);
      @(negedge clk);
      chk(hs_en && !ls_en, "R9 high side after guard", int'({hs_en, ls_en}), 2);

      chk(n_overlap == 0, "R8 enables never overlap", n_overlap, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule